// File: doc/BRIEF.md
# Multi-Rate Upsampling Data Generator

This block feeds a reconfigurable interpolating pulse-shaping filter with upsampled data. A single serial baseband bit stream enters on the master clock. Three capture lanes each hold a 16-bit shift register and take in the same input bit, one at every 4th, every 6th and every 8th master cycle. These three rates match interpolation factors of 4, 6 and 8. The filters for those factors have 25, 37 and 49 taps, and each splits into polyphase branches of 7 taps, since 25/4, 37/6 and 49/8 all round up to 7. The three rates are single-cycle enable strobes in the master clock domain, not separate clocks. The strobe counters all start together at reset, so the three sample grids keep a fixed phase to one another.

A 2-bit rate selector picks which lane drives the output. The output is a zero-stuffed stream at the master rate. On a strobe cycle of the selected lane, the output word holds that lane's freshly shifted contents and the valid flag is high. On every other cycle the word is zero and valid is low. The output has no ready input and applies no back-pressure. The input bit is taken on strobe cycles whether or not anything downstream is listening, because the sample grid is set by the master clock and cannot stall. A consumer must accept every word in the cycle it is offered.

A new selector value does not switch the output at once. The output keeps following the old lane until the first strobe of the newly chosen rate. From that strobe on, the new lane drives the output.

Top module: `mr_upsampler`

## Requirements
- R1: After a synchronous reset, `up_valid` is 0, `up_data` is 0 and every lane register is zero. With `rate_sel` = 00 and `ser_in` held at 1 from the first cycle after reset, the first valid word is 16'h0001.
- R2: While `rate_sel` is held steady at factor N, `up_valid` is high for exactly one cycle in every N. The first pulse after reset follows the N-th rising edge after reset is released.
- R3: At each of its strobes, a lane shifts left by one and places `ser_in` in bit 0. The valid word is that lane's register after the shift, so bit 0 holds the newest sample and bit 15 the oldest.
- R4: Whenever `up_valid` is low, `up_data` is all zeros.
- R5: All three lanes capture at their own rates at all times, whatever the selection. After a switch, the first word from the new lane already holds bits that lane captured before the switch.
- R6: The `rate_sel` encoding is 00 for factor 4, 01 for factor 6 and 10 for factor 8. The value 11 behaves exactly like 00.
- R7: A `rate_sel` change takes effect at the next strobe of the newly selected rate. Until then, output continues from the previously active lane at its rate. After reset, the active lane is the factor-4 lane.
- R8: Asserting `rst` in mid-run clears all lanes, the strobe counters and the active selection. Timing and data afterwards match those that follow the initial reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous reset, active high |
| ser_in | input | 1 | Serial baseband data bit |
| rate_sel | input | 2 | Interpolation factor select (00:4, 01:6, 10:8, 11:4) |
| up_data | output | 16 | Zero-stuffed upsampled data word |
| up_valid | output | 1 | High on cycles that carry a sampled word |

## Verification
Two events can land in the same cycle: a strobe of the previously active lane and the first strobe of a newly selected rate. This happens at master cycles that are common multiples of two factors, such as 12 or 24. The bench changes `rate_sel` just before such coincidences, and also toggles it every few cycles so that a pending choice is overwritten before it lands. A behavioural reference model is compared with the outputs on every cycle. A coincidence passes only if exactly one valid word appears and it carries the newly selected lane's contents.

// File: rtl/mr_upsampler_pkg.sv
package mr_upsampler_pkg;

  localparam int NUM_LANES = 3;
  localparam int LANE_IDX_W = 2;

  typedef logic [LANE_IDX_W-1:0] lane_idx_t;

  localparam lane_idx_t LANE_X4 = 2'd0;
  localparam lane_idx_t LANE_X6 = 2'd1;
  localparam lane_idx_t LANE_X8 = 2'd2;

  // Selector decode: 01 -> factor-6 lane, 10 -> factor-8 lane,
  // 00 and 11 -> factor-4 lane.
  function automatic lane_idx_t sel_to_lane(input logic [1:0] sel);
    lane_idx_t idx;
    case (sel)
      2'b01:   idx = LANE_X6;
      2'b10:   idx = LANE_X8;
      default: idx = LANE_X4;
    endcase
    return idx;
  endfunction

endpackage

// File: rtl/mr_rate_strobe.sv
module mr_rate_strobe #(
  parameter int DIV = 4
) (
  input  logic clk,
  input  logic rst,
  output logic strobe
);

  localparam int CNT_W = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(DIV - 1);

  logic [CNT_W-1:0] cnt_q;

  assign strobe = (cnt_q == LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (strobe) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

endmodule

// File: rtl/mr_capture_lane.sv
module mr_capture_lane #(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              take,
  input  logic              bit_in,
  output logic [DATA_W-1:0] word_next
);

  logic [DATA_W-1:0] shreg_q;

  // Value the register holds after this cycle's shift; offered to the
  // output stage so the word leaving on a strobe includes the new bit.
  assign word_next = {shreg_q[DATA_W-2:0], bit_in};

  always_ff @(posedge clk) begin
    if (rst) begin
      shreg_q <= '0;
    end else if (take) begin
      shreg_q <= word_next;
    end
  end

endmodule

// File: rtl/mr_lane_arbiter.sv
module mr_lane_arbiter
  import mr_upsampler_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic                              clk,
  input  logic                              rst,
  input  logic [1:0]                        sel,
  input  logic [NUM_LANES-1:0]              fire,
  input  logic [NUM_LANES-1:0][DATA_W-1:0]  words,
  output logic [DATA_W-1:0]                 data_out,
  output logic                              valid_out
);

  lane_idx_t active_q;
  lane_idx_t req_lane;
  lane_idx_t pick;
  logic      req_fires;
  logic      act_fires;
  logic      emit;

  assign req_lane  = sel_to_lane(sel);
  assign req_fires = fire[req_lane];
  assign act_fires = fire[active_q];

  // The requested lane wins as soon as its own strobe arrives; before
  // that the currently active lane keeps its cadence.
  always_comb begin
    pick = active_q;
    emit = 1'b0;
    if (req_fires) begin
      pick = req_lane;
      emit = 1'b1;
    end else if (act_fires) begin
      pick = active_q;
      emit = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      active_q  <= LANE_X4;
      data_out  <= '0;
      valid_out <= 1'b0;
    end else begin
      if (req_fires) begin
        active_q <= req_lane;
      end
      valid_out <= emit;
      data_out  <= emit ? words[pick] : '0;
    end
  end

endmodule

// File: rtl/mr_upsampler.sv
module mr_upsampler
  import mr_upsampler_pkg::*;
#(
  parameter int DATA_W   = 16,
  parameter int FACTOR_A = 4,
  parameter int FACTOR_B = 6,
  parameter int FACTOR_C = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ser_in,
  input  logic [1:0]        rate_sel,
  output logic [DATA_W-1:0] up_data,
  output logic              up_valid
);

  localparam int FACTORS [NUM_LANES] = '{FACTOR_A, FACTOR_B, FACTOR_C};

  logic [NUM_LANES-1:0]             lane_fire;
  logic [NUM_LANES-1:0][DATA_W-1:0] lane_word;

  for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
    mr_rate_strobe #(
      .DIV (FACTORS[g])
    ) u_strobe (
      .clk    (clk),
      .rst    (rst),
      .strobe (lane_fire[g])
    );

    mr_capture_lane #(
      .DATA_W (DATA_W)
    ) u_capture (
      .clk       (clk),
      .rst       (rst),
      .take      (lane_fire[g]),
      .bit_in    (ser_in),
      .word_next (lane_word[g])
    );
  end

  mr_lane_arbiter #(
    .DATA_W (DATA_W)
  ) u_arbiter (
    .clk       (clk),
    .rst       (rst),
    .sel       (rate_sel),
    .fire      (lane_fire),
    .words     (lane_word),
    .data_out  (up_data),
    .valid_out (up_valid)
  );

endmodule

// File: rtl/mr_upsampler_chk.sv
module mr_upsampler_chk #(
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              ser_in,
  input logic [DATA_W-1:0] up_data,
  input logic              up_valid
);

  logic [3:0] gap_q;

  always_ff @(posedge clk) begin
    if (rst || up_valid) gap_q <= '0;
    else if (gap_q != 4'hF) gap_q <= gap_q + 1'b1;
  end

  // R4: zero stuffing between samples
  assert_stuff_zero_R4: assert property (@(posedge clk) disable iff (rst)
    !up_valid |-> (up_data == '0));

  // R2: the fastest rate is one word in four cycles, so never back to back
  assert_no_back_to_back_R2: assert property (@(posedge clk) disable iff (rst)
    up_valid |=> !up_valid);

  // R7: even across a switch the longest gap is one slow period
  assert_gap_bound_R7: assert property (@(posedge clk) disable iff (rst)
    gap_q < 4'd8);

  // R3: newest captured bit sits in bit 0
  assert_newest_bit_R3: assert property (@(posedge clk) disable iff (rst)
    up_valid |-> (up_data[0] == $past(ser_in)));

endmodule

bind mr_upsampler mr_upsampler_chk #(.DATA_W(DATA_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .ser_in   (ser_in),
  .up_data  (up_data),
  .up_valid (up_valid)
);

// File: tb/mr_upsampler_tb.sv
module mr_upsampler_tb;

  localparam int W = 16;
  localparam int WATCHDOG = 20000;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         ser_in = 1'b0;
  logic [1:0]   rate_sel = 2'b00;
  logic [W-1:0] up_data;
  logic         up_valid;

  always #4 clk = ~clk;

  mr_upsampler u_dut (
    .clk      (clk),
    .rst      (rst),
    .ser_in   (ser_in),
    .rate_sel (rate_sel),
    .up_data  (up_data),
    .up_valid (up_valid)
  );

  // Behavioural reference
  int           factor [3] = '{4, 6, 8};
  logic [W-1:0] m_lane [3];
  int           m_edge = 0;
  int           m_active = 0;
  logic         exp_valid = 1'b0;
  logic [W-1:0] exp_data = '0;
  bit           check_on = 1'b0;
  string        vtag = "R1";
  string        dtag = "R1";

  int n_checks = 0;
  int n_fail = 0;
  int cycles = 0;

  function automatic int decode(input logic [1:0] s);
    if (s == 2'b01) return 1;
    if (s == 2'b10) return 2;
    return 0;
  endfunction

  always @(posedge clk) begin
    cycles++;
    if (rst) begin
      for (int k = 0; k < 3; k++) m_lane[k] = '0;
      m_edge = 0;
      m_active = 0;
      exp_valid = 1'b0;
      exp_data = '0;
    end else begin
      bit fired [3];
      int req;
      m_edge++;
      for (int k = 0; k < 3; k++) begin
        fired[k] = (m_edge % factor[k]) == 0;
        if (fired[k]) m_lane[k] = {m_lane[k][W-2:0], ser_in};
      end
      req = decode(rate_sel);
      if (fired[req]) begin
        m_active = req;
        exp_valid = 1'b1;
        exp_data = m_lane[req];
      end else if (fired[m_active]) begin
        exp_valid = 1'b1;
        exp_data = m_lane[m_active];
      end else begin
        exp_valid = 1'b0;
        exp_data = '0;
      end
    end
  end

  always @(negedge clk) begin
    if (check_on) begin
      n_checks++;
      if (up_valid !== exp_valid) begin
        n_fail++;
        $display("FAIL %s valid at cycle %0d: actual %b expected %b", vtag, cycles, up_valid, exp_valid);
      end
      n_checks++;
      if (up_data !== exp_data) begin
        n_fail++;
        $display("FAIL %s data at cycle %0d: actual %h expected %h",
                 exp_valid ? dtag : "R4", cycles, up_data, exp_data);
      end
    end
  end

  task automatic run(input int n, input bit rnd, input bit fixed);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      ser_in = rnd ? 1'($urandom & 1) : fixed;
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
  endtask

  initial begin
    // R1: reset state and first word
    do_reset();
    check_on = 1'b1;
    vtag = "R1"; dtag = "R1";
    ser_in = 1'b1;
    run(6, 1'b0, 1'b1);
    // R2 / R3: steady factor 4 with random data
    vtag = "R2"; dtag = "R3";
    run(100, 1'b1, 1'b0);
    // R7 / R5: switch to factor 6 and then 8
    rate_sel = 2'b01;
    vtag = "R7"; dtag = "R5";
    run(120, 1'b1, 1'b0);
    rate_sel = 2'b10;
    run(120, 1'b1, 1'b0);
    // R6: value 11 acts as factor 4
    rate_sel = 2'b11;
    vtag = "R6"; dtag = "R6";
    run(80, 1'b1, 1'b0);
    // R7: rapid toggling so pending choices collide with strobes
    vtag = "R7"; dtag = "R7";
    for (int j = 0; j < 60; j++) begin
      rate_sel = 2'(j % 3);
      run(1 + (j % 5), 1'b1, 1'b0);
    end
    rate_sel = 2'b01;
    run(50, 1'b1, 1'b0);
    // R8: reset in mid-run with factor 8 selected
    rate_sel = 2'b10;
    run(13, 1'b1, 1'b0);
    vtag = "R8"; dtag = "R8";
    do_reset();
    run(100, 1'b1, 1'b0);
    check_on = 1'b0;
    @(negedge clk);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end

  initial begin
    #(8 * WATCHDOG);
    n_checks++;
    n_fail++;
    $display("FAIL R2 watchdog: actual %0d cycles expected under %0d", cycles, WATCHDOG);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end

endmodule